// File: doc/BRIEF.md
# Double-Buffered Transmit Gate Schedule Executor

This block plays a cyclic gate control list for one Ethernet egress port, as a time-aware shaper does. Software loads gate commands into a command store that is split into two banks. On every cycle-start pulse the executor walks the active bank from its first word and drives an 8-bit transmit-allow mask, one bit per priority. Each command opens a set of priorities for a number of transmitted data units: bytes when the link runs at gigabit speed and nibbles at 10/100 speed. The time base and the pulse generator sit outside the block.

Software prepares the next schedule in the idle bank and then points the bank select at it. The executor moves to the new bank only at the next cycle start, so a running list is never changed while it plays. A status bit shows the bank in use, and a second bit shows when that bank equals the selected bank, which means the other bank is free to rewrite. Two sticky flags report a command count that is too short and a list that runs past the end of its bank.

Top module: `gate_sched_exec`

## Requirements
- R1: A command word holds the allow mask in bits [7:0] and the unit count in bits [21:8]. Bits [31:22] have no effect. On the write port, address bit 6 selects the bank and bits [5:0] select the word.
- R2: If either `port_en` or `global_en` is low, `allow_mask` is all ones in the same cycle. Start pulses are ignored, and the list stays idle until a start pulse comes while both enables are high.
- R3: A start pulse with both enables high loads word 0 of the selected bank. Its mask appears on `allow_mask` in the cycle after the edge. Before the first start pulse the mask is all ones.
- R4: A command with effective count C holds its mask for C counted slots plus one clock. The following word is then loaded. With a slot strobe in every cycle, word j starts at cycle offset sum over i<j of (C_i+1).
- R5: A command with count 0 ends the list. Its mask stays on `allow_mask` until the next start pulse.
- R6: A count from 1 to 15 is executed as 16 and sets `cnt_err`. `cnt_err` holds until a start pulse clears it. The start pulse's own word 0 can set it again.
- R7: When the last word of the bank (word 63) finishes with no terminating command, `addr_err` sets and `allow_mask` becomes all ones. Both hold until the next start pulse clears them.
- R8: While both enables are high, `active_bank` changes only at a start pulse, where it takes `next_bank`. While disabled, it follows `next_bank` one clock later. `bank_free` is high when `active_bank` equals `next_bank`.
- R9: With `speed_gig` high only `byte_tick` counts. With it low only `nib_tick` counts. The other strobe has no effect.
- R10: A start pulse in the middle of a list abandons that list and restarts at word 0.
- R11: After reset, `active_bank` is 0, both error flags are 0 and `allow_mask` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command write strobe |
| wr_addr | input | 7 | Bank bit 6, word index bits 5:0 |
| wr_data | input | 32 | Command word |
| port_en | input | 1 | Port-level schedule enable |
| global_en | input | 1 | Global schedule enable |
| next_bank | input | 1 | Bank requested for the next cycle |
| speed_gig | input | 1 | 1: count bytes, 0: count nibbles |
| byte_tick | input | 1 | One pulse per byte sent |
| nib_tick | input | 1 | One pulse per nibble sent |
| cyc_start | input | 1 | Cycle-start pulse |
| allow_mask | output | 8 | Per-priority transmit allow |
| active_bank | output | 1 | Bank currently executing |
| bank_free | output | 1 | Active bank equals requested bank |
| cnt_err | output | 1 | Short count seen this cycle |
| addr_err | output | 1 | List ran off the end of the bank |

## Verification
The outputs follow fixed latencies:

- The enables gate `allow_mask` combinationally, so an enable change shows in the same cycle.
- A start pulse, a command load, a bank change and a flag update each take exactly one clock edge.
- A running command adds one edge per counted slot and one edge for the load.

The bench drives every input on the falling edge and samples on the next falling edge. Its expected mask for each sample comes from a running sum of (count+1) over the command list. Each expected value is therefore tied to an exact cycle offset from the start pulse.

// File: rtl/gsx_pkg.sv
package gsx_pkg;
   localparam int unsigned GSX_BUS_W = 32;
   localparam int unsigned GSX_BANKS = 2;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_RUN   = 2'd1,
      SQ_HOLD  = 2'd2,
      SQ_FAULT = 2'd3
   } sq_state_e;
endpackage

// File: rtl/gsx_tick_sel.sv
module gsx_tick_sel (
   input  logic speed_gig,
   input  logic byte_tick,
   input  logic nib_tick,
   output logic tick
);
   // unit of the count follows the link speed
   assign tick = speed_gig ? byte_tick : nib_tick;
endmodule

// File: rtl/gsx_cmd_ram.sv
module gsx_cmd_ram #(
   parameter int unsigned CMD_W = 22,
   parameter int unsigned DEPTH = 64,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic             wr_bank,
   input  logic [AW-1:0]    wr_idx,
   input  logic [CMD_W-1:0] wr_word,
   input  logic             rd_bank,
   input  logic [AW-1:0]    rd_idx,
   output logic [CMD_W-1:0] rd_word
);
   import gsx_pkg::*;

   logic [CMD_W-1:0] bank_rd [GSX_BANKS];

   for (genvar b = 0; b < GSX_BANKS; b++) begin : g_bank
      logic [CMD_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_bank == 1'(b)))
            mem[wr_idx] <= wr_word;
      end
      assign bank_rd[b] = mem[rd_idx];
   end

   assign rd_word = bank_rd[rd_bank];
endmodule

// File: rtl/gsx_bank_ctrl.sv
module gsx_bank_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic start,
   input  logic next_bank,
   output logic active_bank,
   output logic rd_bank,
   output logic bank_free
);
   logic act_q;

   // swap only at a cycle boundary; with the schedule off, follow at once
   always_ff @(posedge clk) begin
      if (!rst_n)
         act_q <= 1'b0;
      else if (!en || start)
         act_q <= next_bank;
   end

   assign active_bank = act_q;
   assign rd_bank     = start ? next_bank : act_q;
   assign bank_free   = (act_q == next_bank);
endmodule

// File: rtl/gsx_seq.sv
module gsx_seq #(
   parameter int unsigned NPRI        = 8,
   parameter int unsigned CNT_W       = 14,
   parameter int unsigned DEPTH       = 64,
   parameter int unsigned MIN_CNT     = 16,
   parameter bit          CLAMP_SHORT = 1'b1,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned CMD_W = NPRI + CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             start,
   input  logic             tick,
   input  logic [CMD_W-1:0] rd_word,
   output logic [AW-1:0]    rd_idx,
   output logic [NPRI-1:0]  allow_mask,
   output logic             cnt_err,
   output logic             addr_err
);
   import gsx_pkg::*;

   localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);
   localparam logic [CNT_W-1:0] MIN_C    = CNT_W'(MIN_CNT);

   sq_state_e        st_q;
   logic [AW-1:0]    idx_q;
   logic [CNT_W-1:0] cnt_q;
   logic [NPRI-1:0]  mask_q;
   logic             ce_q, ae_q;

   logic [CNT_W-1:0] cmd_cnt, eff_cnt;
   logic [NPRI-1:0]  cmd_allow;
   logic             cmd_short, cnt_zero, at_last, step, do_load;

   assign cmd_allow = rd_word[NPRI-1:0];
   assign cmd_cnt   = rd_word[NPRI +: CNT_W];
   assign cmd_short = (cmd_cnt != '0) && (cmd_cnt < MIN_C);

   if (CLAMP_SHORT) begin : g_clamp
      assign eff_cnt = cmd_short ? MIN_C : cmd_cnt;
   end else begin : g_raw
      assign eff_cnt = cmd_cnt;
   end

   assign cnt_zero = (cnt_q == '0);
   assign at_last  = (idx_q == LAST_IDX);
   assign step     = (st_q == SQ_RUN) && cnt_zero;
   assign do_load  = start || (step && !at_last);
   assign rd_idx   = start ? '0 : idx_q + AW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         idx_q  <= '0;
         cnt_q  <= '0;
         mask_q <= '1;
         ce_q   <= 1'b0;
         ae_q   <= 1'b0;
      end else if (!en) begin
         st_q <= SQ_IDLE;
      end else begin
         if (start)
            ae_q <= 1'b0;
         if (do_load) begin
            idx_q  <= rd_idx;
            mask_q <= cmd_allow;
            ce_q   <= (ce_q & ~start) | cmd_short;
            if (cmd_cnt == '0) begin
               st_q  <= SQ_HOLD;
               cnt_q <= '0;
            end else begin
               st_q  <= SQ_RUN;
               cnt_q <= eff_cnt;
            end
         end else if (step) begin
            st_q <= SQ_FAULT;
            ae_q <= 1'b1;
         end else if ((st_q == SQ_RUN) && tick) begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end

   assign allow_mask = (en && ((st_q == SQ_RUN) || (st_q == SQ_HOLD))) ? mask_q : '1;
   assign cnt_err    = ce_q;
   assign addr_err   = ae_q;
endmodule

// File: rtl/gate_sched_exec.sv
module gate_sched_exec #(
   parameter int unsigned NPRI        = 8,
   parameter int unsigned CNT_W       = 14,
   parameter int unsigned DEPTH       = 64,
   parameter int unsigned MIN_CNT     = 16,
   parameter bit          CLAMP_SHORT = 1'b1,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned CMD_W = NPRI + CNT_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [AW:0]     wr_addr,
   input  logic [31:0]     wr_data,
   input  logic            port_en,
   input  logic            global_en,
   input  logic            next_bank,
   input  logic            speed_gig,
   input  logic            byte_tick,
   input  logic            nib_tick,
   input  logic            cyc_start,
   output logic [NPRI-1:0] allow_mask,
   output logic            active_bank,
   output logic            bank_free,
   output logic            cnt_err,
   output logic            addr_err
);
   if (CMD_W > 32) begin : g_bad_width
      $error("command fields exceed the 32-bit write word");
   end
   if ((1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_depth
      $error("bank depth must be a power of two of at least 2");
   end
   if (MIN_CNT == 0 || MIN_CNT >= (1 << CNT_W)) begin : g_bad_min
      $error("minimum count out of range for the count field");
   end

   logic             en, tick, rd_bank;
   logic [AW-1:0]    rd_idx;
   logic [CMD_W-1:0] rd_word;

   assign en = port_en & global_en;

   if (CMD_W < 32) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wr_data[31:CMD_W];
   end

   gsx_tick_sel u_tick (
      .speed_gig (speed_gig),
      .byte_tick (byte_tick),
      .nib_tick  (nib_tick),
      .tick      (tick)
   );

   gsx_bank_ctrl u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en),
      .start       (cyc_start),
      .next_bank   (next_bank),
      .active_bank (active_bank),
      .rd_bank     (rd_bank),
      .bank_free   (bank_free)
   );

   gsx_cmd_ram #(.CMD_W(CMD_W), .DEPTH(DEPTH)) u_ram (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_bank (wr_addr[AW]),
      .wr_idx  (wr_addr[AW-1:0]),
      .wr_word (wr_data[CMD_W-1:0]),
      .rd_bank (rd_bank),
      .rd_idx  (rd_idx),
      .rd_word (rd_word)
   );

   gsx_seq #(
      .NPRI(NPRI), .CNT_W(CNT_W), .DEPTH(DEPTH),
      .MIN_CNT(MIN_CNT), .CLAMP_SHORT(CLAMP_SHORT)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .start      (cyc_start),
      .tick       (tick),
      .rd_word    (rd_word),
      .rd_idx     (rd_idx),
      .allow_mask (allow_mask),
      .cnt_err    (cnt_err),
      .addr_err   (addr_err)
   );
endmodule

// File: rtl/gsx_checker.sv
module gsx_checker #(
   parameter int unsigned NPRI = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            port_en,
   input logic            global_en,
   input logic            cyc_start,
   input logic            next_bank,
   input logic            active_bank,
   input logic [NPRI-1:0] allow_mask,
   input logic            cnt_err,
   input logic            addr_err
);
   AST_GATES_OPEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !(port_en && global_en) |-> (allow_mask == '1)); // R2

   AST_BANK_HELD_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && global_en && !cyc_start) |=> (active_bank == $past(active_bank))); // R8

   AST_BANK_TAKEN_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && global_en && cyc_start) |=> (active_bank == $past(next_bank))); // R8

   AST_FAULT_OPENS_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_err && port_en && global_en) |-> (allow_mask == '1)); // R7

   AST_ADDR_ERR_CLEARS_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(addr_err) |-> $past(cyc_start && port_en && global_en)); // R7

   AST_CNT_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_err && !cyc_start) |=> cnt_err); // R6
endmodule

bind gate_sched_exec gsx_checker #(.NPRI(NPRI)) u_chk (.*);

// File: tb/gate_sched_exec_test.sv
module gate_sched_exec_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [6:0]  wr_addr;
   logic [31:0] wr_data;
   logic        port_en, global_en, next_bank, speed_gig;
   logic        byte_tick, nib_tick, cyc_start;
   logic [7:0]  allow_mask;
   logic        active_bank, bank_free, cnt_err, addr_err;

   int          n_chk = 0;
   int          n_fail = 0;
   bit          finished = 1'b0;

   int          m_cnt [2][64];
   logic [7:0]  m_msk [2][64];

   always #4 clk = ~clk;

   gate_sched_exec uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .port_en(port_en), .global_en(global_en), .next_bank(next_bank),
      .speed_gig(speed_gig), .byte_tick(byte_tick), .nib_tick(nib_tick),
      .cyc_start(cyc_start), .allow_mask(allow_mask), .active_bank(active_bank),
      .bank_free(bank_free), .cnt_err(cnt_err), .addr_err(addr_err)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic wr(int b, int idx, logic [31:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 7'((b << 6) | idx);
      wr_data = d;
      m_cnt[b][idx] = int'((d >> 8) & 32'h3FFF);
      m_msk[b][idx] = d[7:0];
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // expected outputs k cycles after the start edge, slot strobe every cycle
   task automatic calc(int b, int k, output logic [7:0] m, output logic ae, output logic ce);
      int pos = 0;
      ae = 1'b0; ce = 1'b0; m = 8'hFF;
      for (int j = 0; j < 64; j++) begin
         int c = m_cnt[b][j];
         int e = (c < 16) ? 16 : c;
         if (c != 0 && c < 16) ce = 1'b1;
         if (c == 0) begin m = m_msk[b][j]; return; end
         if (k <= pos + e) begin m = m_msk[b][j]; return; end
         pos += e + 1;
      end
      ae = 1'b1;
      m  = 8'hFF;
   endtask

   task automatic run(int b, int n, string tag);
      logic [7:0] em;
      logic ea, ec;
      @(negedge clk);
      cyc_start = 1'b1;
      @(negedge clk);
      cyc_start = 1'b0;
      chk({tag, " R3 active bank"}, 32'(active_bank), 32'(b));
      for (int k = 0; k < n; k++) begin
         calc(b, k, em, ea, ec);
         chk({tag, " mask"}, 32'(allow_mask), 32'(em));
         chk({tag, " flags"}, {30'd0, addr_err, cnt_err}, {30'd0, ea, ec});
         @(negedge clk);
      end
   endtask

   initial begin
      #1600000;
      if (!finished) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      port_en = 1'b0; global_en = 1'b0; next_bank = 1'b0; speed_gig = 1'b0;
      byte_tick = 1'b0; nib_tick = 1'b1; cyc_start = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 mask", 32'(allow_mask), 32'hFF);
      chk("R11 bank", 32'(active_bank), 0);
      chk("R11 flags", {30'd0, addr_err, cnt_err}, 0);
      chk("R11 free", 32'(bank_free), 1);

      // bank 0 list; word 2 carries junk above bit 21 (R1)
      wr(0, 0, 32'h0000_1001);
      wr(0, 1, 32'h0000_1402);
      wr(0, 2, 32'hFFC0_1003);
      wr(0, 3, 32'h0000_0080);
      port_en = 1'b1; global_en = 1'b1;
      @(negedge clk);
      chk("R3 idle before start", 32'(allow_mask), 32'hFF);

      run(0, 90, "R4 R5 R1");
      run(0, 30, "R4");
      run(0, 40, "R10");

      // bank 1 with short counts (R6)
      wr(1, 0, 32'h0000_0510);
      wr(1, 1, 32'h0000_2820);
      wr(1, 2, 32'h0000_0340);
      wr(1, 3, 32'h0000_00C3);
      run(0, 10, "R4");
      next_bank = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk("R8 bank held mid-cycle", 32'(active_bank), 0);
         chk("R8 bank not free", 32'(bank_free), 0);
      end
      run(1, 120, "R6");
      chk("R8 free after swap", 32'(bank_free), 1);
      next_bank = 1'b0;
      run(0, 20, "R6 cleared");

      // R9: gigabit mode ignores the nibble strobe
      speed_gig = 1'b1; byte_tick = 1'b0; nib_tick = 1'b1;
      run(0, 1, "R9");
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         chk("R9 nibble strobe ignored", 32'(allow_mask), 32'h01);
      end
      byte_tick = 1'b1; nib_tick = 1'b0;
      run(0, 70, "R9");

      // R2: either enable low opens all gates
      run(0, 5, "R2");
      port_en = 1'b0;
      #1;
      chk("R2 port_en low", 32'(allow_mask), 32'hFF);
      @(negedge clk);
      port_en = 1'b1;
      #1;
      chk("R2 idle after re-enable", 32'(allow_mask), 32'hFF);
      run(0, 5, "R2");
      global_en = 1'b0;
      #1;
      chk("R2 global_en low", 32'(allow_mask), 32'hFF);
      @(negedge clk);
      cyc_start = 1'b1;
      @(negedge clk);
      cyc_start = 1'b0;
      chk("R2 start ignored while off", 32'(allow_mask), 32'hFF);
      next_bank = 1'b1;
      @(negedge clk);
      chk("R8 follows select while off", 32'(active_bank), 1);
      chk("R8 free while off", 32'(bank_free), 1);
      next_bank = 1'b0;
      @(negedge clk);
      chk("R8 follows back", 32'(active_bank), 0);
      global_en = 1'b1;
      @(negedge clk);
      chk("R2 idle until start", 32'(allow_mask), 32'hFF);

      // R7: bank 1 filled with no terminating word
      for (int j = 0; j < 64; j++)
         wr(1, j, 32'(32'h0000_1000 | j));
      next_bank = 1'b1;
      run(1, 1100, "R7");
      next_bank = 1'b0;
      run(0, 5, "R7 cleared");

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule